// File: doc/BRIEF.md
# Word-Serial Burst Event Transmitter

This block reads events out of a pixel array in which each pixel can hold one pending contrast event with a polarity (ON for a rise in light, OFF for a fall). Events are written into a behavioural pending-flag matrix through an inject port. Any row that holds a pending pixel raises a row request. A round-robin arbiter grants one requesting row at a time. On the grant, the block copies that row's ON and OFF column flags into a latch and issues the row address as the first word of a burst. It then sends one column word for each latched pixel, lowest column index first.

Words leave through a registered valid/ready stream. Each word has a kind bit (row or column), an address and a polarity bit. When the last column word of a burst has been accepted, the pixels that were served have their pending flags cleared. A row whose flags are all clear drops its request. Pixels that fired during the burst stay pending and are served in a later burst.

Top module: `evt_burst_tx`

## Requirements
- R1: After synchronous reset, out_valid is low and no word is produced until an event is injected.
- R2: An inject marks the pixel pending with its polarity. An inject at a pixel that is already pending changes nothing, and the pixel keeps its first polarity.
- R3: A burst is one row word (out_kind = 0, out_addr = row index, out_on = 0) followed by one column word for each latched pixel (out_kind = 1, out_addr = column index, out_on = 1 for ON, 0 for OFF).
- R4: Within a burst, column words come out in strictly ascending column index. Column 0 is the leftmost.
- R5: The column flags are latched in the cycle the row is granted. A pixel of that row that fires later is left out of the current burst and served in a later one.
- R6: Rows are granted round-robin. After row r is served, the next burst goes to the first requesting row after r in circular order, so r itself is granted again only after all other waiting rows.
- R7: When a burst ends, the served pixels are cleared. No word is repeated, and a served pixel can fire again afterwards.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_kind, out_addr and out_on hold their values.
- R9: When the block is idle, an event sampled on the inject port at rising edge k shows its row word after edge k+1. With out_ready high, its first column word shows after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Inject a pixel event this cycle |
| ev_row | input | 8 | Row of the injected event |
| ev_col | input | 8 | Column of the injected event |
| ev_on | input | 1 | Polarity of the injected event, 1 = ON |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_kind | output | 1 | 0 = row word, 1 = column word |
| out_addr | output | 8 | Row or column address |
| out_on | output | 1 | Column word polarity, 1 = ON; 0 for row words |

## Verification
The row word of an idle-time event is due after the second rising edge that follows the inject, and its first column word is due one edge later. The bench samples on falling edges at exactly those points. All other words are matched in order by a monitor that pops a scoreboard queue only on cycles where out_valid and out_ready are both high. Ordering runs do not depend on cycle counts: the bench holds out_ready low while one burst is open, injects every other event, and only then predicts the full round-robin sequence. The bench then toggles out_ready in a stutter pattern and checks on each cycle that a stalled word stays in place.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic {
    WORD_ROW = 1'b0,
    WORD_COL = 1'b1
  } word_kind_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } tx_state_e;
endpackage

// File: rtl/evt_pixel_store.sv
module evt_pixel_store #(
  parameter int ROWS = 180,
  parameter int COLS = 240,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inj_valid,
  input  logic [RW-1:0]   inj_row,
  input  logic [CW-1:0]   inj_col,
  input  logic            inj_on,
  input  logic [RW-1:0]   rd_row,
  output logic [COLS-1:0] rd_on,
  output logic [COLS-1:0] rd_off,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_row,
  input  logic [COLS-1:0] clr_on,
  input  logic [COLS-1:0] clr_off,
  output logic [ROWS-1:0] row_req
);
  logic [COLS-1:0] on_mem  [ROWS];
  logic [COLS-1:0] off_mem [ROWS];

  logic            in_range, inj_ok, same_row;
  logic [COLS-1:0] on_keep, off_keep;

  always_comb begin
    in_range = (int'(inj_row) < ROWS) && (int'(inj_col) < COLS);
    inj_ok   = inj_valid && in_range &&
               !(on_mem[inj_row][inj_col] || off_mem[inj_row][inj_col]);
    same_row = clr_en && inj_ok && (inj_row == clr_row);
    on_keep  = on_mem[clr_row]  & ~clr_on;
    off_keep = off_mem[clr_row] & ~clr_off;
    if (same_row) begin
      if (inj_on) on_keep[inj_col]  = 1'b1;
      else        off_keep[inj_col] = 1'b1;
    end
  end

  assign rd_on  = on_mem[rd_row];
  assign rd_off = off_mem[rd_row];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        on_mem[r]  <= '0;
        off_mem[r] <= '0;
      end
      row_req <= '0;
    end else begin
      if (clr_en) begin
        on_mem[clr_row]  <= on_keep;
        off_mem[clr_row] <= off_keep;
        row_req[clr_row] <= |(on_keep | off_keep);
      end
      if (inj_ok && !same_row) begin
        if (inj_on) on_mem[inj_row][inj_col]  <= 1'b1;
        else        off_mem[inj_row][inj_col] <= 1'b1;
        row_req[inj_row] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_rr_arbiter.sv
module evt_rr_arbiter #(
  parameter int N = 180,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(ptr) + i;
      if (idx >= N) idx = idx - N;
      if (!gnt_valid && req[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (advance && gnt_valid)
      ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
  end

  // R6
  grant_is_requested_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> req[gnt_idx]);

  // R6
  pointer_leaves_served_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && gnt_valid) |=> (ptr != $past(gnt_idx)));
endmodule

// File: rtl/evt_col_scan.sv
module evt_col_scan #(
  parameter int N = 240,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << idx) - N'(1);

  // R4
  leftmost_pick_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> (vec[idx] && ((vec & below_mask) == '0)));
endmodule

// File: rtl/evt_burst_tx.sv
module evt_burst_tx #(
  parameter int ROWS = 180,
  parameter int COLS = 240,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int AW = (RW > CW) ? RW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [RW-1:0] ev_row,
  input  logic [CW-1:0] ev_col,
  input  logic          ev_on,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_kind,
  output logic [AW-1:0] out_addr,
  output logic          out_on
);
  import evt_pkg::*;

  tx_state_e       state;
  logic [RW-1:0]   cur_row;
  logic [COLS-1:0] lat_on, lat_off, snap_on, snap_off;
  logic [COLS-1:0] rd_on, rd_off;
  logic [ROWS-1:0] row_req;
  logic            gnt_valid, advance, can_load, col_found, clr_en;
  logic [RW-1:0]   gnt_idx;
  logic [CW-1:0]   col_idx;

  assign can_load = !out_valid || out_ready;
  assign advance  = (state == ST_IDLE) && gnt_valid;
  assign clr_en   = (state == ST_BURST) && can_load && !col_found;

  evt_pixel_store #(.ROWS(ROWS), .COLS(COLS)) store_i (
    .clk(clk), .rst(rst),
    .inj_valid(ev_valid), .inj_row(ev_row), .inj_col(ev_col), .inj_on(ev_on),
    .rd_row(gnt_idx), .rd_on(rd_on), .rd_off(rd_off),
    .clr_en(clr_en), .clr_row(cur_row), .clr_on(snap_on), .clr_off(snap_off),
    .row_req(row_req)
  );

  evt_rr_arbiter #(.N(ROWS)) arb_i (
    .clk(clk), .rst(rst), .req(row_req), .advance(advance),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  evt_col_scan #(.N(COLS)) scan_i (
    .clk(clk), .rst(rst), .vec(lat_on | lat_off),
    .found(col_found), .idx(col_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_row   <= '0;
      lat_on    <= '0;
      lat_off   <= '0;
      snap_on   <= '0;
      snap_off  <= '0;
      out_valid <= 1'b0;
      out_kind  <= 1'b0;
      out_addr  <= '0;
      out_on    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (gnt_valid) begin
          cur_row   <= gnt_idx;
          lat_on    <= rd_on;
          lat_off   <= rd_off;
          snap_on   <= rd_on;
          snap_off  <= rd_off;
          out_valid <= 1'b1;
          out_kind  <= logic'(WORD_ROW);
          out_addr  <= AW'(gnt_idx);
          out_on    <= 1'b0;
          state     <= ST_BURST;
        end
        ST_BURST: if (can_load) begin
          if (col_found) begin
            out_valid        <= 1'b1;
            out_kind         <= logic'(WORD_COL);
            out_addr         <= AW'(col_idx);
            out_on           <= lat_on[col_idx];
            lat_on[col_idx]  <= 1'b0;
            lat_off[col_idx] <= 1'b0;
          end else begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
                                   $stable(out_addr) && $stable(out_on)));

  // R3
  row_word_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == logic'(WORD_ROW)) |-> !out_on);

  // R3
  burst_opens_row_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_kind == logic'(WORD_ROW)));

  // R3
  col_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == logic'(WORD_COL)) |-> (int'(out_addr) < COLS));
endmodule

// File: tb/evt_burst_tx_tb_top.sv
`timescale 1ns/1ps
module evt_burst_tx_tb_top;
  localparam int ROWS = 180;
  localparam int COLS = 240;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [7:0] ev_row = '0;
  logic [7:0] ev_col = '0;
  logic       ev_on = 1'b0;
  logic       out_valid, out_kind, out_on;
  logic       out_ready = 1'b1;
  logic [7:0] out_addr;

  always #2.5 clk = ~clk;

  evt_burst_tx #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_row(ev_row),
    .ev_col(ev_col), .ev_on(ev_on), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_addr(out_addr),
    .out_on(out_on)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    q_kind[$];
  int    q_addr[$];
  int    q_on[$];
  string q_tag[$];

  bit m_pend [ROWS][COLS];
  bit m_on   [ROWS][COLS];

  int rdy_mode = 0;  // 0 high, 1 low, 2 stutter
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_word(input int kind, input int addr, input int on, input string tag);
    q_kind.push_back(kind);
    q_addr.push_back(addr);
    q_on.push_back(on);
    q_tag.push_back(tag);
  endtask

  task automatic model_inject(input int r, input int c, input bit on);
    if (!m_pend[r][c]) begin
      m_pend[r][c] = 1'b1;
      m_on[r][c]   = on;
    end
  endtask

  task automatic build_expected(input int start);
    for (int i = 0; i < ROWS; i++) begin
      int  r;
      bit  any;
      r   = (start + i) % ROWS;
      any = 1'b0;
      for (int c = 0; c < COLS; c++) any |= m_pend[r][c];
      if (any) begin
        push_word(0, r, 0, "R6 row order");
        for (int c = 0; c < COLS; c++) begin
          if (m_pend[r][c]) begin
            if (r == 10 && c == 3)     push_word(1, c, m_on[r][c], "R5 late pixel");
            else if (r == 3 && c == 7) push_word(1, c, m_on[r][c], "R2 first polarity kept");
            else                       push_word(1, c, m_on[r][c], "R4 column order");
            m_pend[r][c] = 1'b0;
          end
        end
      end
    end
  endtask

  // inputs change 1 ns after the rising edge
  task automatic inject(input int r, input int c, input bit on);
    ev_valid = 1'b1;
    ev_row   = 8'(r);
    ev_col   = 8'(c);
    ev_on    = on;
    @(posedge clk); #1;
    ev_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = (cyc % 3) != 0;
    endcase
  end

  // scoreboard monitor and stall checks (R8)
  bit pv = 0, pr = 0, pk = 0, po = 0;
  int pa = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pv && !pr) begin
        chk(out_valid && out_kind == pk && int'(out_addr) == pa && out_on == po,
            "R8 stalled word held", int'(out_addr), pa);
      end
      if (out_valid && out_ready) begin
        if (q_kind.size() == 0) begin
          chk(1'b0, "R7 unexpected word", int'(out_addr), -1);
        end else begin
          int    ek, ea, eo;
          string et;
          ek = q_kind.pop_front();
          ea = q_addr.pop_front();
          eo = q_on.pop_front();
          et = q_tag.pop_front();
          chk(int'(out_kind) == ek, {et, " kind"}, int'(out_kind), ek);
          chk(int'(out_addr) == ea, {et, " addr"}, int'(out_addr), ea);
          chk(int'(out_on) == eo,   {et, " polarity"}, int'(out_on), eo);
        end
      end
      pv = out_valid; pr = out_ready; pk = out_kind; pa = int'(out_addr); po = out_on;
    end
  end

  task automatic wait_drain(input string tag);
    for (int i = 0; i < 3000 && q_kind.size() != 0; i++) @(posedge clk);
    chk(q_kind.size() == 0, {tag, " all words delivered"}, q_kind.size(), 0);
    repeat (8) begin
      @(negedge clk);
      chk(!out_valid, "R7 no repeated word after drain", int'(out_valid), 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: idle after reset
    repeat (5) begin
      @(negedge clk);
      chk(!out_valid, "R1 idle after reset", int'(out_valid), 0);
    end

    // R9 latency and R3 burst format
    @(posedge clk); #1;
    push_word(0, 5, 0, "R3 row word");
    push_word(1, 17, 1, "R3 column word");
    inject(5, 17, 1'b1);
    @(negedge clk);
    chk(!out_valid, "R9 no word one edge after inject", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid && !out_kind && out_addr == 8'd5, "R9 row word after edge k+1",
        int'(out_addr), 5);
    @(negedge clk);
    chk(out_valid && out_kind && out_addr == 8'd17, "R9 column word after edge k+2",
        int'(out_addr), 17);
    wait_drain("R3");

    // gated ordering run: R2 R4 R5 R6 R8
    @(posedge clk); #1;
    rdy_mode = 1;
    @(posedge clk); #1;
    push_word(0, 10, 0, "R6 first row");
    push_word(1, 100, 0, "R3 first column");
    inject(10, 100, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    model_inject(10, 100, 1'b0);
    inject(10, 3, 1'b1);    model_inject(10, 3, 1'b1);
    inject(10, 100, 1'b1);  model_inject(10, 100, 1'b1);
    inject(3, 200, 1'b1);   model_inject(3, 200, 1'b1);
    inject(3, 7, 1'b0);     model_inject(3, 7, 1'b0);
    inject(3, 239, 1'b1);   model_inject(3, 239, 1'b1);
    inject(179, 0, 1'b0);   model_inject(179, 0, 1'b0);
    inject(11, 5, 1'b1);    model_inject(11, 5, 1'b1);
    inject(0, 0, 1'b1);     model_inject(0, 0, 1'b1);
    inject(3, 7, 1'b1);     model_inject(3, 7, 1'b1);
    m_pend[10][100] = 1'b0;  // served by the open burst
    build_expected(11);
    @(negedge clk);
    chk(out_valid && !out_kind && out_addr == 8'd10, "R8 row word held while stalled",
        int'(out_addr), 10);
    @(posedge clk); #1;
    rdy_mode = 2;
    wait_drain("R6");

    // R7: served pixel fires again
    @(posedge clk); #1;
    rdy_mode = 0;
    @(posedge clk); #1;
    push_word(0, 10, 0, "R7 refire row");
    push_word(1, 100, 1, "R7 refire column");
    inject(10, 100, 1'b1);
    wait_drain("R7");

    finish_run();
  end
endmodule